// File: doc/BRIEF.md
# RTC Update Sequencer and Interrupt Status Controller

This block paces the once-per-second time update of a PC-style real-time clock and keeps its interrupt status. A one-second strobe opens an update window during which an update-in-progress status bit is raised. The window is measured in microsecond ticks, 244 + 1984 = 2228 by default. At its end the block issues a one-cycle commit strobe to the external time counters. The calendar arithmetic lives in those counters and is not part of this block. When the window closes, the block sets the update-ended flag. It also compares the new seconds, minutes and hours against their alarm bytes and sets the alarm flag on a match.

A small control register holds the SET (update hold) bit and three interrupt enables: periodic, alarm and update-ended. Three sticky flags record periodic, alarm and update-ended events whether or not their enables are set. An interrupt summary bit combines each flag with its enable and drives an active-low interrupt line. A status read returns the four bits and clears the three flags in the same cycle. An event that lands in the read cycle is kept, so it appears on the following read.

The sequencer is a four-state machine:
- IDLE waits for a one-second strobe with SET clear. It moves to WAIT.
- WAIT raises update-in-progress and counts microsecond ticks. It moves to COMMIT on the last tick, or back to IDLE on a 0-to-1 write of SET.
- COMMIT lasts one cycle. It pulses the commit strobe with update-in-progress still high, then moves to DONE.
- DONE lasts one cycle with update-in-progress low. It raises the update-ended and alarm-check events, then returns to IDLE.

Top module: `rtc_upd_irq`

## Requirements
- R1: A one-second strobe taken in IDLE while SET is 0 raises `uip` on the next cycle.
- R2: `upd_commit` is high for exactly one cycle. This happens on the cycle after the UIP_US-th microsecond tick counted since the strobe. `uip` stays 1 through that cycle and is 0 on the cycle after it.
- R3: UF (status bit 0) is never set while `uip` is 1. It reads 1 two cycles after the commit strobe.
- R4: While SET is 1, one-second strobes are ignored: `uip` stays 0, no commit is issued and UF is not set.
- R5: A control write that takes SET from 0 to 1 drops `uip` on the next cycle and cancels the pending commit. The same write forces the update-ended enable to 0, whatever value the write carries.
- R6: The alarm flag AF (status bit 1) is set at the end of an update when each of seconds, minutes and hours matches its alarm byte. A byte matches when it equals the time value, or when its top two bits are both 1 (don't care).
- R7: IRQF (status bit 3) is 1 exactly when PF with its enable, AF with its enable, or UF with its enable are both 1. `irq_n` is the inverse of IRQF.
- R8: Each flag is set by its event even while its enable is 0. In that case the flag does not raise IRQF.
- R9: A status read returns `{IRQF, PF, AF, UF}` during the read cycle and clears all flags. This releases `irq_n`.
- R10: An event on the same cycle as a status read is not lost. Its flag reads 1 after the read.
- R11: After reset, the flags, `uip`, SET and all three enables are 0, and `irq_n` is 1.
- R12: A pulse on `per_evt` sets PF (status bit 2) on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-second strobe |
| us_tick | input | 1 | Microsecond tick |
| per_evt | input | 1 | Periodic-rate event pulse |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_set | input | 1 | SET (update hold) value to write |
| ctl_pie | input | 1 | Periodic interrupt enable to write |
| ctl_aie | input | 1 | Alarm interrupt enable to write |
| ctl_uie | input | 1 | Update-ended interrupt enable to write |
| rd_stat | input | 1 | Status read strobe |
| tm_sec | input | FW | Current seconds |
| tm_min | input | FW | Current minutes |
| tm_hr | input | FW | Current hours |
| al_sec | input | FW | Seconds alarm byte |
| al_min | input | FW | Minutes alarm byte |
| al_hr | input | FW | Hours alarm byte |
| uip | output | 1 | Update in progress |
| upd_commit | output | 1 | One-cycle commit strobe to the time counters |
| stat_flags | output | 4 | {IRQF, PF, AF, UF} |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with UIP_US set to 12 and FW left at 8. The short window keeps each update to a few dozen cycles, so the bench can run many full sequences. Those sequences include aborting a window partway through, checking the boundary between tick 11 and tick 12, and checking the exact cycles of the commit and the UF rise. The 8-bit fields keep the don't-care encoding in the top two bits. The near-miss case, with only one of the two top bits set, can therefore be checked directly.

// File: rtl/rtcupd_pkg.sv
package rtcupd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_COMMIT,
        ST_DONE
    } upd_state_e;

    localparam int NUM_FLAGS = 3;
    localparam int FL_UF = 0;
    localparam int FL_AF = 1;
    localparam int FL_PF = 2;
    localparam int NUM_FIELDS = 3;
endpackage

// File: rtl/rtcupd_seq.sv
module rtcupd_seq
    import rtcupd_pkg::*;
#(
    parameter int UIP_US = 2228
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic us_tick,
    input  logic set_q,
    input  logic set_rise,
    output logic uip,
    output logic commit,
    output logic done
);
    localparam int CW = $clog2(UIP_US + 1);
    localparam logic [CW-1:0] LAST = CW'(UIP_US - 1);

    upd_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (sec_tick && !set_q && !set_rise) state_d = ST_WAIT;
            ST_WAIT: begin
                if (set_rise) state_d = ST_IDLE;
                else if (us_tick && cnt_q == LAST) state_d = ST_COMMIT;
            end
            ST_COMMIT: state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (state_q != ST_WAIT)        cnt_q <= '0;
        else if (us_tick && cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        uip    = 1'b0;
        commit = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_WAIT:   uip = 1'b1;
            ST_COMMIT: begin uip = 1'b1; commit = 1'b1; end
            ST_DONE:   done = 1'b1;
            default:   ;
        endcase
    end

    // R1
    uip_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && sec_tick && !set_q && !set_rise) |=> uip);
    // R5
    set_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_rise && state_q == ST_WAIT) |=> !uip);
    // R2
    commit_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (!uip && !commit && done));
    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/rtcupd_alarm.sv
module rtcupd_alarm
    import rtcupd_pkg::*;
#(
    parameter int FW = 8
) (
    input  logic [NUM_FIELDS-1:0][FW-1:0] now_v,
    input  logic [NUM_FIELDS-1:0][FW-1:0] alm_v,
    output logic                          match
);
    logic [NUM_FIELDS-1:0] hit;

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        assign hit[i] = (alm_v[i] == now_v[i]) || (&alm_v[i][FW-1:FW-2]);
    end

    assign match = &hit;
endmodule

// File: rtl/rtcupd_flags.sv
module rtcupd_flags
    import rtcupd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 per_evt,
    input  logic                 alm_evt,
    input  logic                 upd_evt,
    input  logic                 rd_stat,
    input  logic                 pie,
    input  logic                 aie,
    input  logic                 uie,
    output logic [NUM_FLAGS:0]   stat,
    output logic                 irq_n
);
    logic [NUM_FLAGS-1:0] flags_q, evt, ena;
    logic irqf;

    always_comb begin
        evt        = '0;
        evt[FL_PF] = per_evt;
        evt[FL_AF] = alm_evt;
        evt[FL_UF] = upd_evt;
        ena        = '0;
        ena[FL_PF] = pie;
        ena[FL_AF] = aie;
        ena[FL_UF] = uie;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       flags_q <= '0;
        else if (rd_stat) flags_q <= evt;
        else              flags_q <= flags_q | evt;
    end

    assign irqf  = |(flags_q & ena);
    assign stat  = {irqf, flags_q};
    assign irq_n = !irqf;

    // R9
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && evt == '0) |=> (flags_q == '0));
    // R10
    evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_evt || alm_evt || per_evt) |=> (flags_q != '0));
    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stat && flags_q[FL_UF]) |=> flags_q[FL_UF]);
endmodule

// File: rtl/rtc_upd_irq.sv
module rtc_upd_irq
    import rtcupd_pkg::*;
#(
    parameter int UIP_US = 2228,
    parameter int FW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_tick,
    input  logic          us_tick,
    input  logic          per_evt,
    input  logic          ctl_wr,
    input  logic          ctl_set,
    input  logic          ctl_pie,
    input  logic          ctl_aie,
    input  logic          ctl_uie,
    input  logic          rd_stat,
    input  logic [FW-1:0] tm_sec,
    input  logic [FW-1:0] tm_min,
    input  logic [FW-1:0] tm_hr,
    input  logic [FW-1:0] al_sec,
    input  logic [FW-1:0] al_min,
    input  logic [FW-1:0] al_hr,
    output logic          uip,
    output logic          upd_commit,
    output logic [3:0]    stat_flags,
    output logic          irq_n
);
    logic set_q, pie_q, aie_q, uie_q;
    logic set_rise, done, match;
    logic [NUM_FIELDS-1:0][FW-1:0] now_v, alm_v;

    assign set_rise = ctl_wr && ctl_set && !set_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            set_q <= 1'b0;
            pie_q <= 1'b0;
            aie_q <= 1'b0;
            uie_q <= 1'b0;
        end else if (ctl_wr) begin
            set_q <= ctl_set;
            pie_q <= ctl_pie;
            aie_q <= ctl_aie;
            uie_q <= set_rise ? 1'b0 : ctl_uie;
        end
    end

    assign now_v = {tm_hr, tm_min, tm_sec};
    assign alm_v = {al_hr, al_min, al_sec};

    rtcupd_seq #(.UIP_US(UIP_US)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .us_tick  (us_tick),
        .set_q    (set_q),
        .set_rise (set_rise),
        .uip      (uip),
        .commit   (upd_commit),
        .done     (done)
    );

    rtcupd_alarm #(.FW(FW)) i_alarm (
        .now_v (now_v),
        .alm_v (alm_v),
        .match (match)
    );

    rtcupd_flags i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .per_evt (per_evt),
        .alm_evt (done && match),
        .upd_evt (done),
        .rd_stat (rd_stat),
        .pie     (pie_q),
        .aie     (aie_q),
        .uie     (uie_q),
        .stat    (stat_flags),
        .irq_n   (irq_n)
    );

    // R5
    uie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_rise |=> !uie_q);
    // R3
    uf_after_uip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_commit && !rd_stat) |=> ##1 stat_flags[0]);
    // R4
    set_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_q && !uip) |=> !uip);
endmodule

// File: tb/test_rtc_upd_irq.sv
module test_rtc_upd_irq;
    localparam int UIP_US = 12;
    localparam int FW = 8;

    logic clk = 1'b0;
    logic rst_n, sec_tick, us_tick, per_evt, ctl_wr, ctl_set, ctl_pie, ctl_aie, ctl_uie, rd_stat;
    logic [FW-1:0] tm_sec, tm_min, tm_hr, al_sec, al_min, al_hr;
    logic uip, upd_commit, irq_n;
    logic [3:0] stat_flags;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    rtc_upd_irq #(.UIP_US(UIP_US), .FW(FW)) i_rtc_upd_irq (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .us_tick(us_tick),
        .per_evt(per_evt), .ctl_wr(ctl_wr), .ctl_set(ctl_set), .ctl_pie(ctl_pie),
        .ctl_aie(ctl_aie), .ctl_uie(ctl_uie), .rd_stat(rd_stat),
        .tm_sec(tm_sec), .tm_min(tm_min), .tm_hr(tm_hr),
        .al_sec(al_sec), .al_min(al_min), .al_hr(al_hr),
        .uip(uip), .upd_commit(upd_commit), .stat_flags(stat_flags), .irq_n(irq_n)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_ctl(input logic s, input logic p, input logic a, input logic u);
        ctl_wr = 1'b1; ctl_set = s; ctl_pie = p; ctl_aie = a; ctl_uie = u;
        step();
        ctl_wr = 1'b0;
    endtask

    task automatic us_pulse();
        us_tick = 1'b1;
        step();
        us_tick = 1'b0;
        step();
    endtask

    task automatic read_stat(input string tag, input logic [3:0] exp);
        rd_stat = 1'b1;
        #1;
        chk(tag, {4'h0, stat_flags}, {4'h0, exp});
        step();
        rd_stat = 1'b0;
    endtask

    // full update: R1, R2, R3
    task automatic run_update();
        sec_tick = 1'b1;
        step();
        sec_tick = 1'b0;
        chk("R1 uip after strobe", {7'd0, uip}, 8'd1);
        for (int i = 0; i < UIP_US - 1; i++) us_pulse();
        chk("R2 no commit before last tick", {6'd0, uip, upd_commit}, 8'b10);
        us_tick = 1'b1;
        step();
        us_tick = 1'b0;
        chk("R2 commit with uip", {6'd0, uip, upd_commit}, 8'b11);
        step();
        chk("R2 uip drops after commit", {6'd0, uip, upd_commit}, 8'b00);
        chk("R3 UF not yet while window", {7'd0, stat_flags[0]}, 8'd0);
        step();
        chk("R3 UF set after update", {7'd0, stat_flags[0]}, 8'd1);
    endtask

    task automatic t_reset();
        chk("R11 reset uip", {7'd0, uip}, 8'd0);
        chk("R11 reset flags", {4'd0, stat_flags}, 8'd0);
        chk("R11 reset irq_n", {7'd0, irq_n}, 8'd1);
        per_evt = 1'b1;
        step();
        per_evt = 1'b0;
        chk("R12 PF set", {4'd0, stat_flags}, 8'b0100);
        chk("R8 R11 pie off no irq", {7'd0, irq_n}, 8'd1);
        read_stat("R9 read PF", 4'b0100);
        chk("R9 cleared", {4'd0, stat_flags}, 8'd0);
    endtask

    task automatic t_plain_update();
        al_sec = 8'h13; al_min = 8'h34; al_hr = 8'h05;
        run_update();
        chk("R6 R8 mismatch UF only", {4'd0, stat_flags}, 8'b0001);
        chk("R8 uie off no irq", {7'd0, irq_n}, 8'd1);
        read_stat("R9 read UF", 4'b0001);
        chk("R9 flags clear", {4'd0, stat_flags}, 8'd0);
    endtask

    task automatic t_uie_irq();
        wr_ctl(1'b0, 1'b0, 1'b0, 1'b1);
        run_update();
        chk("R7 uie irq", {3'd0, irq_n, stat_flags}, 8'b01001);
        read_stat("R9 read with irq", 4'b1001);
        chk("R9 irq released", {7'd0, irq_n}, 8'd1);
    endtask

    task automatic t_alarm();
        wr_ctl(1'b0, 1'b0, 1'b1, 1'b0);
        al_sec = 8'h12; al_min = 8'h34; al_hr = 8'h05;
        run_update();
        chk("R6 exact match AF", {3'd0, irq_n, stat_flags}, 8'b01011);
        read_stat("R6 read AF", 4'b1011);
        al_sec = 8'hC5; al_min = 8'hFF; al_hr = 8'hC0;
        run_update();
        chk("R6 dont care match", {4'd0, stat_flags}, 8'b1011);
        read_stat("R6 read dc", 4'b1011);
        al_hr = 8'h80;
        run_update();
        chk("R6 one top bit no match", {4'd0, stat_flags}, 8'b0001);
        read_stat("R6 read nm", 4'b0001);
        al_hr = 8'h40;
        run_update();
        chk("R6 other top bit no match", {4'd0, stat_flags}, 8'b0001);
        read_stat("R6 read nm2", 4'b0001);
    endtask

    task automatic t_set_hold();
        wr_ctl(1'b1, 1'b0, 1'b0, 1'b0);
        sec_tick = 1'b1;
        step();
        sec_tick = 1'b0;
        chk("R4 no uip under SET", {7'd0, uip}, 8'd0);
        for (int i = 0; i < UIP_US + 2; i++) begin
            us_pulse();
            if (upd_commit || uip) chk("R4 no commit under SET", {6'd0, uip, upd_commit}, 8'd0);
        end
        chk("R4 no UF under SET", {4'd0, stat_flags}, 8'd0);
        wr_ctl(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_set_abort();
        run_update();
        sec_tick = 1'b1;
        step();
        sec_tick = 1'b0;
        us_pulse();
        us_pulse();
        chk("R5 uip before abort", {7'd0, uip}, 8'd1);
        wr_ctl(1'b1, 1'b0, 1'b0, 1'b1);
        chk("R5 uip cleared by SET", {7'd0, uip}, 8'd0);
        chk("R5 uie forced off", {7'd0, irq_n}, 8'd1);
        for (int i = 0; i < UIP_US; i++) begin
            us_pulse();
            if (upd_commit) chk("R5 commit cancelled", {7'd0, upd_commit}, 8'd0);
        end
        chk("R5 no UF from aborted", {4'd0, stat_flags}, 8'b0001);
        wr_ctl(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R7 uie after re-enable", {3'd0, irq_n, stat_flags}, 8'b01001);
        read_stat("R9 read after abort", 4'b1001);
        wr_ctl(1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_periodic();
        wr_ctl(1'b0, 1'b1, 1'b0, 1'b0);
        per_evt = 1'b1;
        step();
        per_evt = 1'b0;
        chk("R12 R7 PF irq", {3'd0, irq_n, stat_flags}, 8'b01100);
        rd_stat = 1'b1;
        per_evt = 1'b1;
        #1;
        chk("R9 read during event", {4'd0, stat_flags}, 8'b1100);
        step();
        rd_stat = 1'b0;
        per_evt = 1'b0;
        chk("R10 event kept across read", {3'd0, irq_n, stat_flags}, 8'b01100);
        read_stat("R10 second read", 4'b1100);
        chk("R9 all clear", {3'd0, irq_n, stat_flags}, 8'b10000);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected at most 100000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sec_tick = 1'b0; us_tick = 1'b0; per_evt = 1'b0;
        ctl_wr = 1'b0; ctl_set = 1'b0; ctl_pie = 1'b0; ctl_aie = 1'b0; ctl_uie = 1'b0;
        rd_stat = 1'b0;
        tm_sec = 8'h12; tm_min = 8'h34; tm_hr = 8'h05;
        al_sec = 8'h00; al_min = 8'h00; al_hr = 8'h00;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_plain_update();
        t_uie_irq();
        t_alarm();
        t_set_hold();
        t_set_abort();
        t_periodic();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule